// File: doc/BRIEF.md
# Event Timer Control Register Block

This block is the shared register and routing core of a multi-channel event timer. It holds a 64-bit main counter, which advances once per clock while the timer is globally enabled and holds its value while disabled. It also holds the global configuration with its enable and legacy-route bits, a read-only capability word, and a sticky per-channel record of delivered interrupts. For each channel it keeps the configuration, comparator and period registers. The comparator logic itself lives in separate channel blocks. These connect to this block through per-channel arm and disarm pulses, which they receive, and fire strobes, which they return.

Software reaches all state through a 1 KiB window of 32-bit words, using a simple strobe bus that returns read data one clock after the read strobe. A fire strobe from a channel is turned into a one-cycle pulse on one interrupt line. Normally the line is picked by the channel's route field. In legacy mode, channels 0 and 1 are instead forced onto two fixed lines, and a registered legacy flag tells surrounding logic to silence any older timer.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the main counter, the global configuration, every period register and the interrupt history are zero, every comparator reads 0xFFFFFFFF in both halves, and irq_o, arm_o, disarm_o, cnt_wr_warn_o and legacy_o are low.
- R2: Offset 0x000 reads the capability word {vendor id 0x8086, bit 15 = 1 (legacy capable), bit 14 = 0, bit 13 = 1 (64-bit counter), bits 12:8 = channel count minus one, bits 7:0 = revision 0x01}, which is 0x8086A201 for three channels. Offset 0x004 reads the tick period in femtoseconds. Writes to both offsets are ignored.
- R3: Read data appears on rdata_o in the cycle after rd_i is sampled. Offsets with no register read as zero and ignore writes. This covers a misaligned address, offset 0x014, the upper word of a channel configuration (+0x04), and every channel index at or above the channel count (channel n occupies 0x100 + 0x20*n).
- R4: The global configuration at 0x010 stores only bit 0 (enable) and bit 1 (legacy). All other bits read as zero whatever is written.
- R5: While enabled, the main counter, with its low half at 0x0F0 and its high half at 0x0F4, increases by one per clock with carry into the high half. While disabled it holds its value, and after re-enabling it resumes from the held value.
- R6: A write to either counter half replaces that half, and the other half keeps its value from before the write cycle. A counter write made while enabled still takes effect, and cnt_wr_warn_o pulses high for exactly one cycle; a write while disabled raises no warning.
- R7: A write that changes enable from 0 to 1 pulses arm_o for one cycle, with bit n set exactly for channels whose 64-bit comparator is not all-ones.
- R8: A write that changes enable from 1 to 0 pulses every bit of disarm_o for one cycle.
- R9: A channel configuration word (+0x00) stores bit 2 (channel enable) and bits 13:9 (route), and all other bits read as zero. The comparator (+0x08 low, +0x0C high) and the period (+0x10 low, +0x14 high) are 64-bit registers written and read as 32-bit halves.
- R10: A fire_i strobe produces a one-cycle pulse on the routed irq_o line in the following cycle, but only if both the channel enable and the global enable are set. A route value at or above the number of lines drives no line.
- R11: With legacy set, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. All other channels, and all channels when legacy is clear, use their route field.
- R12: legacy_o is a registered copy of the global legacy bit.
- R13: The status word at 0x020 has bit n set once an interrupt of channel n has been delivered. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 10 | Byte address in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after rd_i |
| fire_i | input | NUM_CH | Per-channel fire strobes |
| arm_o | output | NUM_CH | Per-channel arm pulses |
| disarm_o | output | NUM_CH | Per-channel disarm pulses |
| irq_o | output | IRQ_LINES | Interrupt line pulses |
| legacy_o | output | 1 | Legacy mode active |
| cnt_wr_warn_o | output | 1 | Counter written while running |

## Verification
The bench sweeps every route value, including those past the last line, for every channel in both legacy settings. A design that ignored the override, or let an oversized route wrap onto a real line, would raise the wrong line. Counter checks cover freezing, resuming from the held value and a carry across the 32-bit boundary. A counter that restarted from zero on enable, or lost the carry, would read back a wrong value. The arm mask is checked with only some comparators still all-ones, which catches a design that arms every channel. Reads past the last channel must return zero, so a decoder that aliased channel indices would show stale data.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_CAP_LO,
        RK_CAP_HI,
        RK_GCFG,
        RK_STAT,
        RK_CNT_LO,
        RK_CNT_HI,
        RK_CH_CFG,
        RK_CMP_LO,
        RK_CMP_HI,
        RK_PER_LO,
        RK_PER_HI
    } reg_kind_e;

    localparam int CH_IDX_W = 5;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CH_IDX_W-1:0]   ch;
    } reg_sel_t;

    // global word offsets
    localparam logic [9:0] OFF_CAP_LO = 10'h000;
    localparam logic [9:0] OFF_CAP_HI = 10'h004;
    localparam logic [9:0] OFF_GCFG   = 10'h010;
    localparam logic [9:0] OFF_STAT   = 10'h020;
    localparam logic [9:0] OFF_CNT_LO = 10'h0F0;
    localparam logic [9:0] OFF_CNT_HI = 10'h0F4;

    // channel region
    localparam logic [9:0] CH_BASE    = 10'h100;
    localparam logic [4:0] CH_CFG     = 5'h00;
    localparam logic [4:0] CH_CMP_LO  = 5'h08;
    localparam logic [4:0] CH_CMP_HI  = 5'h0C;
    localparam logic [4:0] CH_PER_LO  = 5'h10;
    localparam logic [4:0] CH_PER_HI  = 5'h14;

endpackage

// File: rtl/evt_timer_decode.sv
module evt_timer_decode
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [9:0] addr_i,
    output reg_sel_t   sel_o
);

    logic [9:0] rel;
    logic [4:0] off;
    logic [CH_IDX_W-1:0] idx;

    always_comb begin
        sel_o.kind = RK_NONE;
        sel_o.ch   = '0;
        rel        = addr_i - CH_BASE;
        idx        = rel[9:5];
        off        = rel[4:0];
        if (addr_i[1:0] != 2'b00) begin
            sel_o.kind = RK_NONE;
        end else if (addr_i >= CH_BASE) begin
            if (int'(idx) < NUM_CH) begin
                sel_o.ch = idx;
                case (off)
                    CH_CFG:    sel_o.kind = RK_CH_CFG;
                    CH_CMP_LO: sel_o.kind = RK_CMP_LO;
                    CH_CMP_HI: sel_o.kind = RK_CMP_HI;
                    CH_PER_LO: sel_o.kind = RK_PER_LO;
                    CH_PER_HI: sel_o.kind = RK_PER_HI;
                    default:   sel_o.kind = RK_NONE;
                endcase
            end
        end else begin
            case (addr_i)
                OFF_CAP_LO: sel_o.kind = RK_CAP_LO;
                OFF_CAP_HI: sel_o.kind = RK_CAP_HI;
                OFF_GCFG:   sel_o.kind = RK_GCFG;
                OFF_STAT:   sel_o.kind = RK_STAT;
                OFF_CNT_LO: sel_o.kind = RK_CNT_LO;
                OFF_CNT_HI: sel_o.kind = RK_CNT_HI;
                default:    sel_o.kind = RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evt_timer_irq_route.sv
module evt_timer_irq_route #(
    parameter int NUM_CH     = 3,
    parameter int IRQ_LINES  = 24,
    parameter int RT_W       = 5,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8
) (
    input  logic                             legacy_i,
    input  logic [NUM_CH-1:0]                deliver_i,
    input  logic [NUM_CH-1:0][RT_W-1:0]      route_i,
    output logic [IRQ_LINES-1:0]             lines_o
);

    logic [IRQ_LINES-1:0] per_ch [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb begin
            per_ch[g] = '0;
            if (deliver_i[g]) begin
                if (legacy_i && (g == 0)) begin
                    per_ch[g][LEG_LINE_A] = 1'b1;
                end else if (legacy_i && (g == 1)) begin
                    per_ch[g][LEG_LINE_B] = 1'b1;
                end else if (int'(route_i[g]) < IRQ_LINES) begin
                    per_ch[g][route_i[g]] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        lines_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            lines_o = lines_o | per_ch[i];
        end
    end

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH     = 3,
    parameter int          IRQ_LINES  = 24,
    parameter int          LEG_LINE_A = 0,
    parameter int          LEG_LINE_B = 8,
    parameter logic [31:0] TICK_FS    = 32'd10_000_000,
    parameter logic [15:0] VENDOR_ID  = 16'h8086,
    parameter logic [7:0]  REV_ID     = 8'h01
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  rd_i,
    input  logic                  wr_i,
    input  logic [9:0]            addr_i,
    input  logic [31:0]           wdata_i,
    output logic [31:0]           rdata_o,
    input  logic [NUM_CH-1:0]     fire_i,
    output logic [NUM_CH-1:0]     arm_o,
    output logic [NUM_CH-1:0]     disarm_o,
    output logic [IRQ_LINES-1:0]  irq_o,
    output logic                  legacy_o,
    output logic                  cnt_wr_warn_o
);

    localparam int RT_W   = $clog2(IRQ_LINES);
    localparam int CI_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int RT_LSB = 9;
    localparam int EN_BIT = 2;
    localparam logic [31:0] CAP_LO =
        {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), REV_ID};

    typedef struct packed {
        logic [63:0]                    cnt;
        logic                           en;
        logic                           leg;
        logic [NUM_CH-1:0]              ch_en;
        logic [NUM_CH-1:0][RT_W-1:0]    route;
        logic [NUM_CH-1:0][63:0]        cmp;
        logic [NUM_CH-1:0][63:0]        per;
        logic [NUM_CH-1:0]              hist;
        logic [NUM_CH-1:0]              arm;
        logic [NUM_CH-1:0]              disarm;
        logic [IRQ_LINES-1:0]           irq;
        logic                           warn;
        logic [31:0]                    rdata;
    } state_t;

    state_t   s_d, s_q;
    reg_sel_t sel;
    logic [CI_W-1:0]       chi;
    logic [NUM_CH-1:0]     deliver;
    logic [IRQ_LINES-1:0]  lines;
    logic [31:0]           rd_val;
    logic                  new_en;

    evt_timer_decode #(.NUM_CH(NUM_CH)) dec_i (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    assign chi     = sel.ch[CI_W-1:0];
    assign deliver = fire_i & s_q.ch_en & {NUM_CH{s_q.en}};

    evt_timer_irq_route #(
        .NUM_CH     (NUM_CH),
        .IRQ_LINES  (IRQ_LINES),
        .RT_W       (RT_W),
        .LEG_LINE_A (LEG_LINE_A),
        .LEG_LINE_B (LEG_LINE_B)
    ) route_i (
        .legacy_i  (s_q.leg),
        .deliver_i (deliver),
        .route_i   (s_q.route),
        .lines_o   (lines)
    );

    always_comb begin
        s_d        = s_q;
        s_d.arm    = '0;
        s_d.disarm = '0;
        s_d.warn   = 1'b0;
        new_en     = wdata_i[0];

        if (s_q.en) begin
            s_d.cnt = s_q.cnt + 64'd1;
        end

        // read path
        rd_val = '0;
        case (sel.kind)
            RK_CAP_LO: rd_val = CAP_LO;
            RK_CAP_HI: rd_val = TICK_FS;
            RK_GCFG:   rd_val = {30'd0, s_q.leg, s_q.en};
            RK_STAT:   rd_val = 32'(s_q.hist);
            RK_CNT_LO: rd_val = s_q.cnt[31:0];
            RK_CNT_HI: rd_val = s_q.cnt[63:32];
            RK_CH_CFG: begin
                rd_val[EN_BIT]            = s_q.ch_en[chi];
                rd_val[RT_LSB +: RT_W]    = s_q.route[chi];
            end
            RK_CMP_LO: rd_val = s_q.cmp[chi][31:0];
            RK_CMP_HI: rd_val = s_q.cmp[chi][63:32];
            RK_PER_LO: rd_val = s_q.per[chi][31:0];
            RK_PER_HI: rd_val = s_q.per[chi][63:32];
            default:   rd_val = '0;
        endcase
        if (rd_i) begin
            s_d.rdata = rd_val;
        end

        // write path
        if (wr_i) begin
            case (sel.kind)
                RK_GCFG: begin
                    s_d.en  = new_en;
                    s_d.leg = wdata_i[1];
                    if (!s_q.en && new_en) begin
                        for (int i = 0; i < NUM_CH; i++) begin
                            s_d.arm[i] = (s_q.cmp[i] != {64{1'b1}});
                        end
                    end
                    if (s_q.en && !new_en) begin
                        s_d.disarm = {NUM_CH{1'b1}};
                    end
                end
                RK_CNT_LO: begin
                    s_d.cnt  = {s_q.cnt[63:32], wdata_i};
                    s_d.warn = s_q.en;
                end
                RK_CNT_HI: begin
                    s_d.cnt  = {wdata_i, s_q.cnt[31:0]};
                    s_d.warn = s_q.en;
                end
                RK_CH_CFG: begin
                    s_d.ch_en[chi] = wdata_i[EN_BIT];
                    s_d.route[chi] = wdata_i[RT_LSB +: RT_W];
                end
                RK_CMP_LO: s_d.cmp[chi][31:0]  = wdata_i;
                RK_CMP_HI: s_d.cmp[chi][63:32] = wdata_i;
                RK_PER_LO: s_d.per[chi][31:0]  = wdata_i;
                RK_PER_HI: s_d.per[chi][63:32] = wdata_i;
                default: ;
            endcase
        end

        // interrupt delivery
        s_d.irq  = lines;
        s_d.hist = s_q.hist | deliver;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.cmp    <= {NUM_CH{64'hFFFF_FFFF_FFFF_FFFF}};
        end else begin
            s_q        <= s_d;
        end
    end

    assign rdata_o       = s_q.rdata;
    assign arm_o         = s_q.arm;
    assign disarm_o      = s_q.disarm;
    assign irq_o         = s_q.irq;
    assign legacy_o      = s_q.leg;
    assign cnt_wr_warn_o = s_q.warn;

    AST_CAP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == 10'h000) |=> (rdata_o == CAP_LO)); // R2
    AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(s_q.en) && !$past(wr_i)) |-> $stable(s_q.cnt)); // R5
    AST_WARN_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_warn_o |-> $past(s_q.en)); // R6
    AST_ARM_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|arm_o) |-> (s_q.en && !$past(s_q.en))); // R7
    AST_DISARM_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|disarm_o) |-> (disarm_o == {NUM_CH{1'b1}} && !s_q.en)); // R8
    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> $past(s_q.en)); // R10
    AST_LEGACY_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.leg && s_q.en && s_q.ch_en[0] && fire_i[0]) |=> irq_o[LEG_LINE_A]); // R11
    AST_HIST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(s_q.hist) & ~s_q.hist) == '0); // R13

endmodule

// File: tb/evt_timer_regs_tb.sv
module evt_timer_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 3;
    localparam int NLINE = 24;
    localparam logic [31:0] TICK = 32'd10_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0, wr = 1'b0;
    logic [9:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] fire = '0;
    logic [NCH-1:0] arm, disarm;
    logic [NLINE-1:0] irq;
    logic legacy, warn;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evt_timer_regs dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .fire_i(fire), .arm_o(arm),
        .disarm_o(disarm), .irq_o(irq), .legacy_o(legacy),
        .cnt_wr_warn_o(warn)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = rdata;
        rd = 1'b0;
    endtask

    function automatic logic [9:0] ch_addr(input int ch, input int off);
        return 10'(32'h100 + 32'h20 * ch + off);
    endfunction

    function automatic logic [NLINE-1:0] exp_line(input int ch, input int r, input bit leg);
        logic [NLINE-1:0] v = '0;
        if (leg && ch == 0) v[0] = 1'b1;
        else if (leg && ch == 1) v[8] = 1'b1;
        else if (r < NLINE) v[r] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, held;
        logic [31:0] cap_exp;
        cap_exp = {16'h8086, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), 8'h01};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 arm", 64'(arm), 64'd0);
        chk("R1 disarm", 64'(disarm), 64'd0);
        chk("R1 warn", 64'(warn), 64'd0);
        chk("R1 legacy", 64'(legacy), 64'd0);
        bus_rd(10'h0F0, v); chk("R1 cnt lo", 64'(v), 64'd0);
        bus_rd(10'h0F4, v); chk("R1 cnt hi", 64'(v), 64'd0);
        bus_rd(10'h010, v); chk("R1 gcfg", 64'(v), 64'd0);
        bus_rd(10'h020, v); chk("R1 status", 64'(v), 64'd0);
        for (int c = 0; c < NCH; c++) begin
            bus_rd(ch_addr(c, 8'h08), v);  chk("R1 cmp lo", 64'(v), 64'hFFFF_FFFF);
            bus_rd(ch_addr(c, 8'h0C), v);  chk("R1 cmp hi", 64'(v), 64'hFFFF_FFFF);
            bus_rd(ch_addr(c, 8'h10), v);  chk("R1 per lo", 64'(v), 64'd0);
            bus_rd(ch_addr(c, 8'h14), v);  chk("R1 per hi", 64'(v), 64'd0);
        end

        // R2 capability
        bus_rd(10'h000, v); chk("R2 cap lo", 64'(v), 64'(cap_exp));
        chk("R2 cap value", 64'(v), 64'h8086_A201);
        bus_rd(10'h004, v); chk("R2 cap hi", 64'(v), 64'(TICK));
        bus_wr(10'h000, 32'h0);
        bus_wr(10'h004, 32'h0);
        bus_rd(10'h000, v); chk("R2 cap lo after write", 64'(v), 64'(cap_exp));
        bus_rd(10'h004, v); chk("R2 cap hi after write", 64'(v), 64'(TICK));

        // R3 holes, misalignment, channels past the end
        bus_wr(10'h014, 32'hFFFF_FFFF);
        bus_rd(10'h014, v); chk("R3 gcfg hi", 64'(v), 64'd0);
        bus_rd(10'h010, v); chk("R3 gcfg untouched", 64'(v), 64'd0);
        bus_rd(10'h001, v); chk("R3 misaligned", 64'(v), 64'd0);
        bus_rd(10'h018, v); chk("R3 hole", 64'(v), 64'd0);
        bus_rd(ch_addr(0, 8'h04), v); chk("R3 ch cfg hi", 64'(v), 64'd0);
        for (int c = NCH; c < 24; c++) begin
            bus_wr(ch_addr(c, 8'h08), 32'h1234_5678);
            bus_rd(ch_addr(c, 8'h08), v); chk("R3 missing channel", 64'(v), 64'd0);
        end
        for (int c = 0; c < NCH; c++) begin
            bus_rd(ch_addr(c, 8'h08), v); chk("R3 no alias", 64'(v), 64'hFFFF_FFFF);
        end

        // R4 global configuration mask, R12 legacy flag
        bus_wr(10'h010, 32'hFFFF_FFFC);
        bus_rd(10'h010, v); chk("R4 masked bits", 64'(v), 64'd0);
        bus_wr(10'h010, 32'h0000_0002);
        bus_rd(10'h010, v); chk("R4 legacy bit", 64'(v), 64'd2);
        chk("R12 legacy_o set", 64'(legacy), 64'd1);
        bus_wr(10'h010, 32'h0);
        chk("R12 legacy_o clear", 64'(legacy), 64'd0);

        // R9 channel registers
        bus_wr(ch_addr(0, 0), 32'hFFFF_FFFF);
        bus_rd(ch_addr(0, 0), v); chk("R9 cfg mask", 64'(v), 64'h3E04);
        bus_wr(ch_addr(0, 0), 32'h0);
        bus_rd(ch_addr(0, 0), v); chk("R9 cfg clear", 64'(v), 64'd0);
        bus_wr(ch_addr(2, 8'h08), 32'h1234_5678);
        bus_wr(ch_addr(2, 8'h0C), 32'h9ABC_DEF0);
        bus_wr(ch_addr(2, 8'h10), 32'h0000_0100);
        bus_wr(ch_addr(2, 8'h14), 32'h0000_0007);
        bus_rd(ch_addr(2, 8'h08), v); chk("R9 cmp lo", 64'(v), 64'h1234_5678);
        bus_rd(ch_addr(2, 8'h0C), v); chk("R9 cmp hi", 64'(v), 64'h9ABC_DEF0);
        bus_rd(ch_addr(2, 8'h10), v); chk("R9 per lo", 64'(v), 64'h100);
        bus_rd(ch_addr(2, 8'h14), v); chk("R9 per hi", 64'(v), 64'h7);
        bus_wr(ch_addr(2, 8'h08), 32'hFFFF_FFFF);
        bus_wr(ch_addr(2, 8'h0C), 32'hFFFF_FFFF);

        // R7 arm mask: only channel 1 has a real comparator
        bus_wr(ch_addr(1, 8'h08), 32'h5);
        bus_wr(10'h010, 32'h1);
        chk("R7 arm mask", 64'(arm), 64'b010);
        @(negedge clk);
        chk("R7 arm one cycle", 64'(arm), 64'd0);

        // R5 running counter
        bus_rd(10'h0F0, v);
        repeat (9) @(negedge clk);
        bus_rd(10'h0F0, v2);
        chk("R5 count rate", 64'(v2 - v), 64'd10);

        // R8 disarm
        bus_wr(10'h010, 32'h0);
        chk("R8 disarm all", 64'(disarm), 64'b111);
        @(negedge clk);
        chk("R8 disarm one cycle", 64'(disarm), 64'd0);

        // R5 frozen then resume
        bus_rd(10'h0F0, v);
        repeat (5) @(negedge clk);
        bus_rd(10'h0F0, held);
        chk("R5 frozen", 64'(held), 64'(v));
        bus_wr(10'h010, 32'h1);
        chk("R7 re-arm", 64'(arm), 64'b010);
        repeat (7) @(negedge clk);
        bus_rd(10'h0F0, v);
        chk("R5 resume from held", 64'(v), 64'(held + 32'd7));

        // R6 counter writes
        bus_wr(10'h0F0, 32'hFFFF_FFF0);
        chk("R6 warn while running", 64'(warn), 64'd1);
        @(negedge clk);
        chk("R6 warn one cycle", 64'(warn), 64'd0);
        bus_wr(10'h010, 32'h0);
        bus_wr(10'h0F4, 32'h0000_00A5);
        chk("R6 no warn when halted", 64'(warn), 64'd0);
        bus_rd(10'h0F4, v); chk("R6 hi written", 64'(v), 64'hA5);
        bus_rd(10'h0F0, v); chk("R6 lo kept", 64'(v), 64'hFFFF_FFF2);
        bus_wr(10'h010, 32'h1);
        repeat (20) @(negedge clk);
        bus_rd(10'h0F0, v); chk("R5 carry lo", 64'(v), 64'h6);
        bus_rd(10'h0F4, v); chk("R5 carry hi", 64'(v), 64'hA6);

        // R10 gating: channel enable clear
        bus_wr(ch_addr(2, 0), 32'(5) << 9);
        fire = 3'b100; @(negedge clk); fire = '0;
        chk("R10 channel disabled", 64'(irq), 64'd0);
        // global enable clear
        bus_wr(ch_addr(2, 0), (32'(5) << 9) | 32'h4);
        bus_wr(10'h010, 32'h0);
        fire = 3'b100; @(negedge clk); fire = '0;
        chk("R10 global disabled", 64'(irq), 64'd0);
        bus_rd(10'h020, v); chk("R13 no history when gated", 64'(v), 64'd0);
        bus_wr(10'h010, 32'h1);
        fire = 3'b100; @(negedge clk); fire = '0;
        chk("R10 delivered", 64'(irq), 64'(1 << 5));
        @(negedge clk);
        chk("R10 one cycle", 64'(irq), 64'd0);
        bus_rd(10'h020, v); chk("R13 history ch2", 64'(v), 64'b100);
        bus_wr(10'h020, 32'h0);
        bus_rd(10'h020, v); chk("R13 write ignored", 64'(v), 64'b100);

        // two channels at once on distinct lines
        bus_wr(ch_addr(0, 0), (32'(3) << 9) | 32'h4);
        fire = 3'b101; @(negedge clk); fire = '0;
        chk("R10 two channels", 64'(irq), 64'((1 << 3) | (1 << 5)));
        @(negedge clk);

        // R11 sweep of every route, channel and legacy setting
        for (int leg = 0; leg < 2; leg++) begin
            bus_wr(10'h010, 32'(leg << 1) | 32'h1);
            for (int c = 0; c < NCH; c++) begin
                for (int r = 0; r < 32; r++) begin
                    bus_wr(ch_addr(c, 0), (32'(r) << 9) | 32'h4);
                    fire = NCH'(1 << c);
                    @(negedge clk);
                    fire = '0;
                    chk("R11 routed line", 64'(irq), 64'(exp_line(c, r, leg[0])));
                    @(negedge clk);
                    chk("R10 pulse ends", 64'(irq), 64'd0);
                end
            end
        end
        bus_rd(10'h020, v); chk("R13 history all", 64'(v), 64'b111);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule